// File: doc/BRIEF.md
# Packed-BCD Calendar Clock on a Byte Port Bus

This block keeps wall-clock time and date as packed-BCD bytes and presents them to a host as seven byte-wide registers. The registers sit at consecutive port addresses, starting at a base address set by a parameter. A one-cycle tick pulse, normally one per second, advances the seconds. A rollover carries through minutes, hours, day of month, month, two-digit year and century. The day of month follows 28, 29, 30 and 31-day months. A two-digit year divisible by four counts as a leap year.

The host loads any register with a single-cycle write strobe and reads any register with a read strobe. Read data is combinational and is valid in the same cycle as the strobe. A host driver finds the clock by reading the seconds register twice, far enough apart that a working clock must have moved on. The driver writes the century byte itself: BCD 19 when the two-digit year is 78 or above, and BCD 20 otherwise.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the registers read seconds 00h, minutes 00h, hours 00h, day 01h, month 01h, year 00h and century 20h.
- R2: Register offsets from the base port are seconds +0, minutes +1, hours +2, day +3, month +4, year +5 and century +6. The default base is 47h. While the read strobe is high at a mapped port, read data equals that register in the same cycle.
- R3: A read of a port outside base+0..base+6, or any cycle with the read strobe low, returns 00h. Reads never change any register.
- R4: Each tick raises seconds by one in BCD through 00h..59h. A tick at 59h gives 00h and passes a carry to minutes.
- R5: Minutes count 00h..59h and hours count 00h..23h. Each passes a carry onward when it wraps to 00h.
- R6: The day of month counts from 01h. Its last day is 30h for months 04h, 06h, 09h and 11h. For month 02h the last day is 29h when the year is divisible by four (00h counts as such) and 28h otherwise. For every other month value the last day is 31h. Past the last day the day becomes 01h and passes a carry to the month.
- R7: Month counts 01h..12h and wraps to 01h with a carry to the year. Year wraps from 99h to 00h with a carry to the century. Century wraps from 99h to 00h.
- R8: A write stores the data byte into the addressed register at the next clock edge. If a tick or carry reaches that register in the same cycle, the write wins. No carry leaves a register that is being written.
- R9: Out-of-range values are stored unchanged. When a carry reaches a field whose value is at or above its last legal value, the field goes to its minimum (01h for day and month, 00h for the others) and carries onward. A value below the limit with a low digit of 9 or more advances to the next tens digit with a low digit of 0.
- R10: Without a tick or a write, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle pulse that advances the time by one second |
| addr | input | 8 | Port address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Byte to write |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data; 00h when no mapped read is active |

## Verification
Directed cases cover the rollovers one at a time:
- The full end-of-century cascade shows whether the carry chain reaches every field.
- February in a leap year and in a non-leap year, and a 30-day month, separate the four month lengths.
- A write in the same cycle as a tick exposes a write/advance priority that is reversed or a carry that is not blocked.
- Out-of-range seconds, hours and month values show whether the wrap compares at-or-above the limit rather than testing for equality.

Seeded random mixes of legal writes, ticks and reads are then checked against a model that counts in binary. This catches wrong limits or minimum values that the fixed dates happen to miss.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int unsigned NUM_FIELDS = 7;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DAY  = 3'd3,
    FLD_MON  = 3'd4,
    FLD_YEAR = 3'd5,
    FLD_CENT = 3'd6
  } fieldIdx_t;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_FIELDS-1:0] load;     // write this field from wrData
    logic [NUM_FIELDS-1:0] advance;  // carry into this field
    logic                  rdHit;    // read strobe on a mapped port
    logic [2:0]            rdIdx;    // which field is being read
  } rtcStrobes_t;

  // Advance a packed-BCD byte by one without any limit check.
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Leap test on a packed-BCD two-digit year: divisible by four.
  function automatic logic bcdLeap(input logic [7:0] yr);
    logic r;
    if (!yr[4]) r = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        r = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return r;
  endfunction

  // Last day of the month in packed BCD.
  function automatic logic [7:0] lastDay(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] r;
    case (mon)
      8'h02:                      r = bcdLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h47
) (
  input  logic                  tickIn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [NUM_FIELDS-1:0] atLimit,
  output rtcStrobes_t           strobes
);

  logic [ADDR_W-1:0] offset;
  logic              mapped;
  logic [NUM_FIELDS-1:0] carryIn;

  assign offset = addr - BASE_ADDR;
  assign mapped = (offset < ADDR_W'(NUM_FIELDS));

  // carry chain; a field being written absorbs the carry
  assign carryIn[0] = tickIn;
  for (genvar i = 1; i < NUM_FIELDS; i++) begin : g_chain
    assign carryIn[i] = carryIn[i-1] & atLimit[i-1] & ~strobes.load[i-1];
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_load
    assign strobes.load[i] = wrEn & mapped & (offset[2:0] == 3'(i));
  end

  assign strobes.advance = carryIn;
  assign strobes.rdHit   = rdEn & mapped;
  assign strobes.rdIdx   = offset[2:0];

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import bcd_rtc_pkg::*;
#(
  parameter logic [7:0] RESET_YEAR    = 8'h00,
  parameter logic [7:0] RESET_CENTURY = 8'h20
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rtcStrobes_t                 strobes,
  input  logic [7:0]                  wrData,
  output logic [NUM_FIELDS-1:0]       atLimit,
  output logic [NUM_FIELDS-1:0][7:0]  fields,
  output logic [7:0]                  rdData
);

  localparam logic [NUM_FIELDS-1:0][7:0] FIELD_MIN =
    {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [NUM_FIELDS-1:0][7:0] FIELD_RST =
    {RESET_CENTURY, RESET_YEAR, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [NUM_FIELDS-1:0][7:0] fieldMax;

  always_comb begin
    fieldMax[FLD_SEC]  = 8'h59;
    fieldMax[FLD_MIN]  = 8'h59;
    fieldMax[FLD_HOUR] = 8'h23;
    fieldMax[FLD_DAY]  = lastDay(fields[FLD_MON], fields[FLD_YEAR]);
    fieldMax[FLD_MON]  = 8'h12;
    fieldMax[FLD_YEAR] = 8'h99;
    fieldMax[FLD_CENT] = 8'h99;
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign atLimit[i] = (fields[i] >= fieldMax[i]);

    always_ff @(posedge clk) begin
      if (!rstN)                   fields[i] <= FIELD_RST[i];
      else if (strobes.load[i])    fields[i] <= wrData;
      else if (strobes.advance[i]) fields[i] <= atLimit[i] ? FIELD_MIN[i] : bcdInc(fields[i]);
    end
  end

  assign rdData = strobes.rdHit ? fields[strobes.rdIdx] : 8'h00;

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h47,
  parameter logic [7:0] RESET_YEAR    = 8'h00,
  parameter logic [7:0] RESET_CENTURY = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData
);

  rtcStrobes_t                strobes;
  logic [NUM_FIELDS-1:0]      atLimit;
  logic [NUM_FIELDS-1:0][7:0] timeFields;

  rtc_ctrl #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_ctrl (
    .tickIn  (tickIn),
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .atLimit (atLimit),
    .strobes (strobes)
  );

  rtc_datapath #(
    .RESET_YEAR    (RESET_YEAR),
    .RESET_CENTURY (RESET_CENTURY)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .atLimit (atLimit),
    .fields  (timeFields),
    .rdData  (rdData)
  );

endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h47
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickIn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [7:0]        wrData,
  input logic              rdEn,
  input logic [7:0]        rdData,
  input logic [6:0][7:0]   fields
);

  logic [ADDR_W-1:0] offs;
  logic              secWrite;
  assign offs     = addr - BASE_ADDR;
  assign secWrite = wrEn && (addr == BASE_ADDR);

  assert_sec_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    secWrite |=> fields[0] == $past(wrData));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !secWrite && fields[0] == 8'h59) |=> fields[0] == 8'h00);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !wrEn) |=> $stable(fields));

  assert_unmapped_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && offs > ADDR_W'(6)) |-> rdData == 8'h00);

  assert_read_no_side_effect_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !tickIn && !wrEn) |=> $stable(fields));

  assert_day_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && fields[3] != 8'h00) |=> fields[3] != 8'h00);

  assert_hour_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && fields[2] <= 8'h23) |=> fields[2] <= 8'h23);

endmodule

bind bcd_rtc bcd_rtc_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .tickIn (tickIn),
  .addr   (addr),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdEn   (rdEn),
  .rdData (rdData),
  .fields (timeFields)
);

// File: tb/bcd_rtc_bench.sv
`timescale 1ns/1ps
module bcd_rtc_bench;

  localparam logic [7:0] BASE = 8'h47;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] mdl [7];

  always #2.5 clk = ~clk;

  bcd_rtc u_bcd_rtc (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData)
  );

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic int monthDays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelTick();
    int lim [7];
    int lo [7];
    bit c = 1'b1;
    lim = '{59, 59, 23, monthDays(b2i(mdl[4]), b2i(mdl[5])), 12, 99, 99};
    lo  = '{0, 0, 0, 1, 1, 0, 0};
    for (int i = 0; i < 7; i++) begin
      if (c) begin
        if (b2i(mdl[i]) >= lim[i]) mdl[i] = i2b(lo[i]);
        else begin mdl[i] = i2b(b2i(mdl[i]) + 1); c = 1'b0; end
      end
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input int idx, input logic [7:0] v);
    @(negedge clk);
    addr = BASE + 8'(idx); wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    mdl[idx] = v;
  endtask

  task automatic doTick();
    @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
    modelTick();
  endtask

  task automatic peek(input int idx, output logic [7:0] v);
    addr = BASE + 8'(idx); rdEn = 1'b1;
    #1;
    v = rdData;
    rdEn = 1'b0;
    #0.1;
  endtask

  task automatic checkAll(input string req);
    logic [7:0] v;
    for (int i = 0; i < 7; i++) begin
      peek(i, v);
      check(req, v, mdl[i]);
    end
  endtask

  task automatic setTime(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                         input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                         input logic [7:0] c);
    doWrite(0, s); doWrite(1, mi); doWrite(2, h);
    doWrite(3, d); doWrite(4, mo); doWrite(5, y); doWrite(6, c);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] v2;
    void'($urandom(32'd20240517));
    mdl = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h20};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values, R2 read map
    checkAll("R1");

    // R3 unmapped ports and idle strobe
    addr = BASE - 8'd1; rdEn = 1'b1; #1; check("R3", rdData, 8'h00); rdEn = 1'b0;
    addr = BASE + 8'd7; rdEn = 1'b1; #1; check("R3", rdData, 8'h00); rdEn = 1'b0;
    addr = BASE + 8'd6; #1; check("R3", rdData, 8'h00);
    // R3 repeated reads leave registers alone
    peek(6, v); peek(6, v2); check("R3", v2, 8'h20);

    // R2 each register at its own offset
    setTime(8'h11, 8'h22, 8'h13, 8'h14, 8'h05, 8'h16, 8'h19);
    checkAll("R2");

    // R4 R5 R7 full cascade, including century
    setTime(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h19);
    doTick();
    checkAll("R7");
    setTime(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h99);
    doTick();
    peek(6, v); check("R7", v, 8'h00);

    // R6 month lengths
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h20);
    doTick(); peek(3, v); check("R6", v, 8'h01); peek(4, v); check("R6", v, 8'h03);
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h20);
    doTick(); peek(3, v); check("R6", v, 8'h29); peek(4, v); check("R6", v, 8'h02);
    setTime(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 8'h20);
    doTick(); peek(3, v); check("R6", v, 8'h29);
    setTime(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h24, 8'h20);
    doTick(); peek(3, v); check("R6", v, 8'h01); peek(4, v); check("R6", v, 8'h05);
    setTime(8'h59, 8'h59, 8'h23, 8'h30, 8'h07, 8'h24, 8'h20);
    doTick(); peek(3, v); check("R6", v, 8'h31);

    // R8 write beats tick on the same register and blocks the carry
    setTime(8'h59, 8'h10, 8'h05, 8'h01, 8'h01, 8'h01, 8'h20);
    @(negedge clk); addr = BASE; wrData = 8'h30; wrEn = 1'b1; tickIn = 1'b1;
    @(negedge clk); wrEn = 1'b0; tickIn = 1'b0;
    peek(0, v); check("R8", v, 8'h30); peek(1, v); check("R8", v, 8'h10);
    setTime(8'h59, 8'h59, 8'h05, 8'h01, 8'h01, 8'h01, 8'h20);
    @(negedge clk); addr = BASE + 8'd1; wrData = 8'h07; wrEn = 1'b1; tickIn = 1'b1;
    @(negedge clk); wrEn = 1'b0; tickIn = 1'b0;
    peek(0, v); check("R8", v, 8'h00); peek(1, v); check("R8", v, 8'h07);
    peek(2, v); check("R8", v, 8'h05);

    // R9 out-of-range handling
    setTime(8'h75, 8'h00, 8'h05, 8'h01, 8'h01, 8'h01, 8'h20);
    peek(0, v); check("R9", v, 8'h75);
    doTick(); peek(0, v); check("R9", v, 8'h00); peek(1, v); check("R9", v, 8'h01);
    setTime(8'h59, 8'h59, 8'h1F, 8'h01, 8'h01, 8'h01, 8'h20);
    doTick(); peek(2, v); check("R9", v, 8'h20);
    setTime(8'h59, 8'h59, 8'h23, 8'h31, 8'h15, 8'h40, 8'h20);
    doTick(); peek(3, v); check("R9", v, 8'h01); peek(4, v); check("R9", v, 8'h01);
    peek(5, v); check("R9", v, 8'h41);

    // R10 hold without ticks
    setTime(8'h42, 8'h17, 8'h09, 8'h12, 8'h08, 8'h33, 8'h20);
    repeat (20) @(negedge clk);
    checkAll("R10");

    // random mix checked against the binary model
    for (int n = 0; n < 4000; n++) begin
      int op;
      int idx;
      int lims [7];
      int los [7];
      lims = '{59, 59, 23, 31, 12, 99, 99};
      los  = '{0, 0, 0, 1, 1, 0, 0};
      op = int'($urandom_range(0, 99));
      idx = int'($urandom_range(0, 6));
      if (op < 70) doTick();
      else if (op < 85) doWrite(idx, i2b(los[idx] + int'($urandom_range(0, lims[idx] - los[idx]))));
      else begin
        peek(idx, v);
        check("R4 R5 R6 R7 random", v, mdl[idx]);
      end
    end
    checkAll("R4 R5 R6 R7 random");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule